// File: doc/BRIEF.md
# Paged Byte-Interleaved SRAM Bridge

This bridge lets a small processor with a 14-bit address bus and an 8-bit data bus reach 1 MB of byte-addressable storage. The storage is two external asynchronous SRAM chips, each holding 16-bit words. A 6-bit page register, loaded by its own strobe, supplies the high-order address bits. The two lowest CPU address bits interleave consecutive bytes. Bit 0 picks the byte lane inside a word, and bit 1 picks the chip. Both chips see one shared word address. Each chip has its own data bus, chip enable, byte enables, write enable and output enable.

A single sequencer turns each one-cycle CPU request into a strobe pattern with fixed timing.

States of the sequencer:
- S_IDLE: both chips deselected.
- S_W_SETUP: one setup cycle of a write.
- S_W_PULSE: the write pulse, `WE_CYCLES` long.
- S_W_HOLD: one hold cycle of a write.
- S_R_WAIT: a read, `RD_WAIT` cycles long, with the output enable low.

Transitions of the sequencer:
- S_IDLE to S_W_SETUP on a write request. A write wins over a read raised in the same cycle.
- S_IDLE to S_R_WAIT on a read request.
- S_W_SETUP to S_W_PULSE always.
- S_W_PULSE to S_W_HOLD on the last pulse cycle.
- S_W_HOLD to S_IDLE always.
- S_R_WAIT to S_IDLE on the last wait cycle, which also captures the read byte.

`cpu_busy` covers every non-idle cycle. `cpu_done` pulses in the first idle cycle after each access.

Top module: `sram_page_bridge`

## Requirements
- R1: After reset the page register is 0. All chip enables, byte enables, write enables and output enables are high, no lane is driven, `cpu_busy` and `cpu_done` are 0, and `cpu_rdata` is 0.
- R2: During an access, `sram_addr` equals {page, cpu_addr[13:2]}, with the page in the upper 6 bits. It holds constant for as long as a chip enable is low.
- R3: cpu_addr[1] selects the chip (0 selects chip 0, 1 selects chip 1). Only the selected chip's active-low enable goes low, and only during an access. The other chip's enables and strobes all stay high, and in idle both chip enables are high.
- R4: cpu_addr[0] selects the lane. A value of 0 selects the lower lane (dq bits 7:0, `sram_lb_n`), and 1 selects the upper lane (dq bits 15:8, `sram_ub_n`). Only the selected lane's enable on the selected chip is low.
- R5: On a write, the CPU byte appears on the selected lane of the selected chip. The drive enable `sram_dq_oe[chip][lane]` is set (index 1 means the upper lane) and all other drive enables are 0. During a read no drive enable is set, and write and output enables are never low together on a chip.
- R6: A write spends 1 setup cycle with the chip enabled and write enable high. It then holds write enable low for exactly `WE_CYCLES` cycles. A final hold cycle follows with write enable high and the chip enable, address and data unchanged.
- R7: A read holds the chip and output enables low for exactly `RD_WAIT` cycles. The selected lane byte is captured at the end of that window, and `cpu_rdata` shows it from the `cpu_done` cycle until the next read completes.
- R8: `cpu_busy` is high in every non-idle cycle, and `cpu_done` is a one-cycle pulse in the first idle cycle. A read or write request raised while busy is ignored.
- R9: A page load in the same cycle as a memory request affects only later accesses, so the request uses the previous page. A read and a write raised together perform the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 14 | CPU byte address within the current page |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_wr | input | 1 | One-cycle write request |
| cpu_rd | input | 1 | One-cycle read request |
| page_wr | input | 1 | Load strobe for the page register |
| page_wdata | input | 6 | New page value |
| cpu_rdata | output | 8 | Last byte read |
| cpu_busy | output | 1 | Access in progress |
| cpu_done | output | 1 | One-cycle completion pulse |
| sram_addr | output | 18 | Shared word address |
| sram_ce_n | output | 2 | Chip enables, one per chip, active low |
| sram_we_n | output | 2 | Write enables, active low |
| sram_oe_n | output | 2 | Output enables, active low |
| sram_ub_n | output | 2 | Upper-byte enables, active low |
| sram_lb_n | output | 2 | Lower-byte enables, active low |
| sram_dq_o | output | 2x16 | Write data per chip |
| sram_dq_oe | output | 2x2 | Drive enable per chip and lane |
| sram_dq_i | input | 2x16 | Read data per chip |

## Verification
A page load can fall in the same cycle as a memory request, and a read request can fall in the same cycle as a write request. The bench raises `page_wr` together with `cpu_wr`. It judges the result from the word address seen in the setup cycle, which must still carry the old page. A later access must carry the new one. The bench also raises `cpu_rd` with `cpu_wr`, and it judges that the bridge drives the lane, keeps the output enable high, and stores the byte, as read back afterwards.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;

    typedef enum logic [2:0] {
        S_IDLE,
        S_W_SETUP,
        S_W_PULSE,
        S_W_HOLD,
        S_R_WAIT
    } seq_state_e;

endpackage

// File: rtl/bridge_page_reg.sv
module bridge_page_reg #(
    parameter int PAGE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [PAGE_W-1:0] data_i,
    output logic [PAGE_W-1:0] page_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_o <= '0;
        end else if (load_i) begin
            page_o <= data_i;
        end
    end

endmodule

// File: rtl/bridge_addr_map.sv
module bridge_addr_map #(
    parameter int CPU_AW    = 14,
    parameter int PAGE_W    = 6,
    parameter int CHIP_BITS = 1,
    localparam int WA       = PAGE_W + CPU_AW - 1 - CHIP_BITS
) (
    input  logic [PAGE_W-1:0]    page_i,
    input  logic [CPU_AW-1:0]    cpu_addr_i,
    output logic [WA-1:0]        word_o,
    output logic [CHIP_BITS-1:0] chip_o,
    output logic                 lane_o
);

    always_comb begin
        lane_o = cpu_addr_i[0];
        chip_o = cpu_addr_i[CHIP_BITS:1];
        word_o = {page_i, cpu_addr_i[CPU_AW-1:CHIP_BITS+1]};
    end

endmodule

// File: rtl/bridge_seq.sv
module bridge_seq
    import bridge_pkg::*;
#(
    parameter int RD_WAIT   = 3,
    parameter int WE_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_req_i,
    input  logic rd_req_i,
    output logic launch_o,
    output logic busy_o,
    output logic ce_act_o,
    output logic we_act_o,
    output logic oe_act_o,
    output logic drive_o,
    output logic capture_o,
    output logic done_o
);

    localparam int MAXC  = (RD_WAIT > WE_CYCLES) ? RD_WAIT : WE_CYCLES;
    localparam int CNT_W = $clog2(MAXC + 1);

    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             we_last, rd_last;

    assign we_last = (cnt_q == CNT_W'(WE_CYCLES - 1));
    assign rd_last = (cnt_q == CNT_W'(RD_WAIT - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
            done_o  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            done_o  <= (state_q == S_W_HOLD) || ((state_q == S_R_WAIT) && rd_last);
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            S_IDLE: begin
                cnt_d = '0;
                if (wr_req_i) begin
                    state_d = S_W_SETUP;
                end else if (rd_req_i) begin
                    state_d = S_R_WAIT;
                end
            end
            S_W_SETUP: begin
                cnt_d   = '0;
                state_d = S_W_PULSE;
            end
            S_W_PULSE: begin
                if (we_last) begin
                    cnt_d   = '0;
                    state_d = S_W_HOLD;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            S_W_HOLD: begin
                state_d = S_IDLE;
            end
            S_R_WAIT: begin
                if (rd_last) begin
                    cnt_d   = '0;
                    state_d = S_IDLE;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                state_d = S_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        launch_o  = 1'b0;
        busy_o    = 1'b1;
        ce_act_o  = 1'b1;
        we_act_o  = 1'b0;
        oe_act_o  = 1'b0;
        drive_o   = 1'b0;
        capture_o = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                busy_o   = 1'b0;
                ce_act_o = 1'b0;
                launch_o = wr_req_i | rd_req_i;
            end
            S_W_SETUP: begin
                drive_o = 1'b1;
            end
            S_W_PULSE: begin
                drive_o  = 1'b1;
                we_act_o = 1'b1;
            end
            S_W_HOLD: begin
                drive_o = 1'b1;
            end
            S_R_WAIT: begin
                oe_act_o  = 1'b1;
                capture_o = rd_last;
            end
            default: begin
                busy_o   = 1'b0;
                ce_act_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/bridge_lane_mux.sv
module bridge_lane_mux
    import bridge_pkg::*;
#(
    parameter int CHIP_BITS = 1,
    parameter int CHIP_IDX  = 0
) (
    input  logic [CHIP_BITS-1:0] chip_i,
    input  logic                 lane_i,
    input  logic                 ce_act_i,
    input  logic                 we_act_i,
    input  logic                 oe_act_i,
    input  logic                 drive_i,
    input  logic [BYTE_W-1:0]    wdata_i,
    output logic                 ce_n_o,
    output logic                 we_n_o,
    output logic                 oe_n_o,
    output logic                 ub_n_o,
    output logic                 lb_n_o,
    output logic [WORD_W-1:0]    dq_o,
    output logic [1:0]           dq_oe_o
);

    logic mine;

    always_comb begin
        mine    = ce_act_i && (chip_i == CHIP_BITS'(CHIP_IDX));
        ce_n_o  = !mine;
        we_n_o  = !(mine && we_act_i);
        oe_n_o  = !(mine && oe_act_i);
        ub_n_o  = !(mine && lane_i);
        lb_n_o  = !(mine && !lane_i);
        dq_o    = {wdata_i, wdata_i};
        dq_oe_o = 2'b00;
        if (mine && drive_i) begin
            dq_oe_o = lane_i ? 2'b10 : 2'b01;
        end
    end

endmodule

// File: rtl/sram_page_bridge.sv
module sram_page_bridge
    import bridge_pkg::*;
#(
    parameter int CPU_AW    = 14,
    parameter int PAGE_W    = 6,
    parameter int NCHIP     = 2,
    parameter int RD_WAIT   = 3,
    parameter int WE_CYCLES = 2,
    localparam int CHIP_BITS = $clog2(NCHIP),
    localparam int WA        = PAGE_W + CPU_AW - 1 - CHIP_BITS
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [CPU_AW-1:0]            cpu_addr,
    input  logic [BYTE_W-1:0]            cpu_wdata,
    input  logic                         cpu_wr,
    input  logic                         cpu_rd,
    input  logic                         page_wr,
    input  logic [PAGE_W-1:0]            page_wdata,
    output logic [BYTE_W-1:0]            cpu_rdata,
    output logic                         cpu_busy,
    output logic                         cpu_done,
    output logic [WA-1:0]                sram_addr,
    output logic [NCHIP-1:0]             sram_ce_n,
    output logic [NCHIP-1:0]             sram_we_n,
    output logic [NCHIP-1:0]             sram_oe_n,
    output logic [NCHIP-1:0]             sram_ub_n,
    output logic [NCHIP-1:0]             sram_lb_n,
    output logic [NCHIP-1:0][WORD_W-1:0] sram_dq_o,
    output logic [NCHIP-1:0][1:0]        sram_dq_oe,
    input  logic [NCHIP-1:0][WORD_W-1:0] sram_dq_i
);

    logic [PAGE_W-1:0]    page_q;
    logic [WA-1:0]        map_word;
    logic [CHIP_BITS-1:0] map_chip;
    logic                 map_lane;

    logic launch, ce_act, we_act, oe_act, drive, capture;

    logic [WA-1:0]        addr_q;
    logic [CHIP_BITS-1:0] chip_q;
    logic                 lane_q;
    logic [BYTE_W-1:0]    wdata_q;
    logic [BYTE_W-1:0]    rdata_q;

    bridge_page_reg #(.PAGE_W(PAGE_W)) u_page (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (page_wr),
        .data_i (page_wdata),
        .page_o (page_q)
    );

    bridge_addr_map #(
        .CPU_AW    (CPU_AW),
        .PAGE_W    (PAGE_W),
        .CHIP_BITS (CHIP_BITS)
    ) u_map (
        .page_i     (page_q),
        .cpu_addr_i (cpu_addr),
        .word_o     (map_word),
        .chip_o     (map_chip),
        .lane_o     (map_lane)
    );

    bridge_seq #(
        .RD_WAIT   (RD_WAIT),
        .WE_CYCLES (WE_CYCLES)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_req_i  (cpu_wr),
        .rd_req_i  (cpu_rd),
        .launch_o  (launch),
        .busy_o    (cpu_busy),
        .ce_act_o  (ce_act),
        .we_act_o  (we_act),
        .oe_act_o  (oe_act),
        .drive_o   (drive),
        .capture_o (capture),
        .done_o    (cpu_done)
    );

    // access latch and read capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            chip_q  <= '0;
            lane_q  <= 1'b0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (launch) begin
                addr_q  <= map_word;
                chip_q  <= map_chip;
                lane_q  <= map_lane;
                wdata_q <= cpu_wdata;
            end
            if (capture) begin
                rdata_q <= lane_q ? sram_dq_i[chip_q][WORD_W-1:BYTE_W]
                                  : sram_dq_i[chip_q][BYTE_W-1:0];
            end
        end
    end

    assign sram_addr = addr_q;
    assign cpu_rdata = rdata_q;

    for (genvar c = 0; c < NCHIP; c++) begin : g_chip
        bridge_lane_mux #(
            .CHIP_BITS (CHIP_BITS),
            .CHIP_IDX  (c)
        ) u_lane (
            .chip_i   (chip_q),
            .lane_i   (lane_q),
            .ce_act_i (ce_act),
            .we_act_i (we_act),
            .oe_act_i (oe_act),
            .drive_i  (drive),
            .wdata_i  (wdata_q),
            .ce_n_o   (sram_ce_n[c]),
            .we_n_o   (sram_we_n[c]),
            .oe_n_o   (sram_oe_n[c]),
            .ub_n_o   (sram_ub_n[c]),
            .lb_n_o   (sram_lb_n[c]),
            .dq_o     (sram_dq_o[c]),
            .dq_oe_o  (sram_dq_oe[c])
        );
    end

endmodule

// File: rtl/bridge_checker.sv
module bridge_checker #(
    parameter int NCHIP = 2,
    parameter int WA    = 18
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cpu_busy,
    input logic                  cpu_done,
    input logic [WA-1:0]         sram_addr,
    input logic [NCHIP-1:0]      sram_ce_n,
    input logic [NCHIP-1:0]      sram_we_n,
    input logic [NCHIP-1:0]      sram_oe_n,
    input logic [NCHIP-1:0]      sram_ub_n,
    input logic [NCHIP-1:0]      sram_lb_n,
    input logic [NCHIP-1:0][1:0] sram_dq_oe
);

    p_one_chip_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~sram_ce_n));

    p_strobe_in_ce_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (((~sram_we_n) | (~sram_oe_n)) & sram_ce_n) == '0);

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_busy |-> (&sram_ce_n));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done);

    p_addr_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|(~sram_ce_n)) |=> ((&sram_ce_n) || $stable(sram_addr)));

    p_we_setup_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|(~sram_we_n)) |-> $past(|(~sram_ce_n)));

    p_we_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(|(~sram_we_n)) |-> (|(~sram_ce_n)));

    p_one_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (((~sram_ub_n) & (~sram_lb_n)) == '0) && (((~sram_ub_n | ~sram_lb_n) & sram_ce_n) == '0));

    p_we_oe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((~sram_we_n) & (~sram_oe_n)) == '0);

    p_no_drive_on_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|(~sram_oe_n)) |-> (sram_dq_oe == '0));

endmodule

bind sram_page_bridge bridge_checker #(.NCHIP(NCHIP), .WA(WA)) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_busy   (cpu_busy),
    .cpu_done   (cpu_done),
    .sram_addr  (sram_addr),
    .sram_ce_n  (sram_ce_n),
    .sram_we_n  (sram_we_n),
    .sram_oe_n  (sram_oe_n),
    .sram_ub_n  (sram_ub_n),
    .sram_lb_n  (sram_lb_n),
    .sram_dq_oe (sram_dq_oe)
);

// File: tb/tb_sram_page_bridge.sv
`timescale 1ns/1ps
module tb_sram_page_bridge;

    localparam int RD_C = 3;
    localparam int WE_C = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_wr = 1'b0;
    logic        cpu_rd = 1'b0;
    logic        page_wr = 1'b0;
    logic [5:0]  page_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        cpu_busy, cpu_done;
    logic [17:0] sram_addr;
    logic [1:0]  sram_ce_n, sram_we_n, sram_oe_n, sram_ub_n, sram_lb_n;
    logic [1:0][15:0] sram_dq_o;
    logic [1:0][1:0]  sram_dq_oe;
    logic [1:0][15:0] sram_dq_i = '0;

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    logic [5:0] cur_page = '0;

    logic [15:0] mem0 [int];
    logic [15:0] mem1 [int];
    logic [7:0]  exp_mem [int];

    always #5 clk = ~clk;

    sram_page_bridge #(.RD_WAIT(RD_C), .WE_CYCLES(WE_C)) dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .page_wr(page_wr), .page_wdata(page_wdata),
        .cpu_rdata(cpu_rdata), .cpu_busy(cpu_busy), .cpu_done(cpu_done),
        .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n),
        .sram_oe_n(sram_oe_n), .sram_ub_n(sram_ub_n), .sram_lb_n(sram_lb_n),
        .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe), .sram_dq_i(sram_dq_i)
    );

    // behavioural SRAM pair
    always @(negedge clk) begin
        for (int c = 0; c < 2; c++) begin
            logic [15:0] w;
            int k;
            k = int'(sram_addr);
            w = 16'h0000;
            if (c == 0 && mem0.exists(k)) w = mem0[k];
            if (c == 1 && mem1.exists(k)) w = mem1[k];
            if (!sram_ce_n[c] && !sram_we_n[c]) begin
                if (!sram_lb_n[c]) w[7:0]  = sram_dq_o[c][7:0];
                if (!sram_ub_n[c]) w[15:8] = sram_dq_o[c][15:8];
                if (c == 0) mem0[k] = w; else mem1[k] = w;
            end
            sram_dq_i[c] = (!sram_ce_n[c] && !sram_oe_n[c]) ? w : 16'h0000;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic set_page(input logic [5:0] p);
        @(negedge clk);
        page_wr = 1'b1; page_wdata = p;
        @(negedge clk);
        page_wr = 1'b0;
        cur_page = p;
    endtask

    task automatic do_write(input logic [13:0] a, input logic [7:0] d,
                            input bit with_page, input logic [5:0] np, input bit with_rd);
        int c = int'(a[1]);
        int ln = int'(a[0]);
        logic [17:0] ew = {cur_page, a[13:2]};
        logic [1:0] sel = 2'(1 << c);
        logic [3:0] eoe = 4'(1 << (c * 2 + ln));
        int lows;
        int key = int'({cur_page, a});
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1; cpu_rd = with_rd;
        if (with_page) begin page_wr = 1'b1; page_wdata = np; end
        @(negedge clk);
        cpu_wr = 1'b0; cpu_rd = 1'b0; page_wr = 1'b0;
        chk(sram_addr == ew, "R2", "write word address", int'(sram_addr), int'(ew));
        if (with_page)
            chk(sram_addr == ew, "R9", "old page used", int'(sram_addr), int'(ew));
        if (with_rd)
            chk(sram_dq_oe != 4'b0 && sram_oe_n == 2'b11, "R9", "write wins",
                int'(sram_oe_n), 3);
        chk(sram_ce_n == ~sel, "R3", "write chip enable", int'(sram_ce_n), int'(~sel));
        chk(sram_we_n == 2'b11 && sram_oe_n == 2'b11, "R6", "setup strobes",
            int'({sram_we_n, sram_oe_n}), 15);
        chk(sram_ub_n == (ln ? ~sel : 2'b11) && sram_lb_n == (ln ? 2'b11 : ~sel), "R4",
            "write lane enables", int'({sram_ub_n, sram_lb_n}),
            int'({(ln ? ~sel : 2'b11), (ln ? 2'b11 : ~sel)}));
        chk(sram_dq_oe == eoe, "R5", "write drive enables", int'(sram_dq_oe), int'(eoe));
        chk((ln ? sram_dq_o[c][15:8] : sram_dq_o[c][7:0]) == d, "R5", "write lane data",
            int'(ln ? sram_dq_o[c][15:8] : sram_dq_o[c][7:0]), int'(d));
        chk(cpu_busy == 1'b1, "R8", "busy during write", int'(cpu_busy), 1);
        if (with_page) cur_page = np;
        @(negedge clk);
        lows = 0;
        while (sram_we_n[c] == 1'b0 && lows < 50) begin
            lows++;
            @(negedge clk);
        end
        chk(lows == WE_C, "R6", "write pulse length", lows, WE_C);
        chk(sram_ce_n[c] == 1'b0 && sram_we_n == 2'b11 && sram_addr == ew && sram_dq_oe == eoe,
            "R6", "hold cycle", int'({sram_ce_n, sram_we_n}), int'({~sel, 2'b11}));
        @(negedge clk);
        chk(cpu_done == 1'b1 && cpu_busy == 1'b0, "R8", "write done pulse",
            int'({cpu_done, cpu_busy}), 2);
        chk(sram_ce_n == 2'b11, "R3", "idle after write", int'(sram_ce_n), 3);
        exp_mem[key] = d;
    endtask

    task automatic do_read(input logic [13:0] a);
        int c = int'(a[1]);
        int ln = int'(a[0]);
        logic [17:0] ew = {cur_page, a[13:2]};
        logic [1:0] sel = 2'(1 << c);
        int key = int'({cur_page, a});
        logic [7:0] ev;
        int lows;
        ev = exp_mem.exists(key) ? exp_mem[key] : 8'h00;
        @(negedge clk);
        cpu_addr = a; cpu_rd = 1'b1;
        @(negedge clk);
        cpu_rd = 1'b0;
        chk(sram_addr == ew, "R2", "read word address", int'(sram_addr), int'(ew));
        chk(sram_ce_n == ~sel && sram_oe_n == ~sel && sram_we_n == 2'b11, "R3",
            "read chip strobes", int'({sram_ce_n, sram_oe_n}), int'({~sel, ~sel}));
        chk(sram_ub_n == (ln ? ~sel : 2'b11) && sram_lb_n == (ln ? 2'b11 : ~sel), "R4",
            "read lane enables", int'({sram_ub_n, sram_lb_n}),
            int'({(ln ? ~sel : 2'b11), (ln ? 2'b11 : ~sel)}));
        chk(sram_dq_oe == 4'b0, "R5", "no drive on read", int'(sram_dq_oe), 0);
        lows = 0;
        while (sram_oe_n[c] == 1'b0 && lows < 50) begin
            lows++;
            @(negedge clk);
        end
        chk(lows == RD_C, "R7", "read window length", lows, RD_C);
        chk(cpu_done == 1'b1 && cpu_busy == 1'b0, "R8", "read done pulse",
            int'({cpu_done, cpu_busy}), 2);
        chk(cpu_rdata == ev, "R7", "read data", int'(cpu_rdata), int'(ev));
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] held;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(sram_ce_n == 2'b11 && sram_we_n == 2'b11 && sram_oe_n == 2'b11, "R1",
            "reset strobes", int'({sram_ce_n, sram_we_n, sram_oe_n}), 63);
        chk(sram_ub_n == 2'b11 && sram_lb_n == 2'b11 && sram_dq_oe == 4'b0, "R1",
            "reset lanes", int'({sram_ub_n, sram_lb_n, sram_dq_oe}), 8'hF0);
        chk(!cpu_busy && !cpu_done && cpu_rdata == 8'h00, "R1", "reset cpu side",
            int'({cpu_busy, cpu_done, cpu_rdata}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 page 0 after reset: addresses checked against cur_page = 0
        do_write(14'h3FFF, 8'hC3, 0, 6'd0, 0);
        do_read(14'h3FFF);

        // near-exhaustive sweep over pages, chips and lanes
        for (int p = 0; p < 64; p++) begin
            set_page(6'(p));
            for (int k = 0; k < 2; k++) begin
                for (int lo = 0; lo < 4; lo++) begin
                    logic [11:0] w = 12'((p * 37 + k * 1111 + 3) & 12'hFFF);
                    logic [13:0] a = {w, 2'(lo)};
                    do_write(a, 8'((p * 7 + int'(a) * 13 + 5) & 8'hFF), 0, 6'd0, 0);
                end
            end
        end
        for (int p = 0; p < 64; p++) begin
            set_page(6'(p));
            for (int k = 0; k < 2; k++) begin
                for (int lo = 0; lo < 4; lo++) begin
                    logic [11:0] w = 12'((p * 37 + k * 1111 + 3) & 12'hFFF);
                    do_read({w, 2'(lo)});
                end
            end
        end

        // R7 read data holds across a write
        held = cpu_rdata;
        do_write(14'h0444, 8'h77, 0, 6'd0, 0);
        chk(cpu_rdata == held, "R7", "read data held", int'(cpu_rdata), int'(held));

        // R9 page load together with a write
        set_page(6'h2A);
        do_write(14'h0103, 8'hA5, 1, 6'h09, 0);
        do_write(14'h0103, 8'h5A, 0, 6'd0, 0);
        do_read(14'h0103);
        set_page(6'h2A);
        do_read(14'h0103);

        // R9 read and write raised together
        do_write(14'h0202, 8'h3C, 0, 6'd0, 1);
        do_read(14'h0202);

        // R8 requests while busy are ignored
        set_page(6'h05);
        @(negedge clk);
        cpu_addr = 14'h0010; cpu_wdata = 8'h11; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_addr = 14'h0021; cpu_wdata = 8'h99; cpu_wr = 1'b1; cpu_rd = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0; cpu_rd = 1'b0;
        for (int i = 0; i < 20 && !cpu_done; i++) @(negedge clk);
        exp_mem[int'({6'h05, 14'h0010})] = 8'h11;
        @(negedge clk);
        chk(sram_ce_n == 2'b11 && !cpu_busy, "R8", "no access launched while busy",
            int'({sram_ce_n, cpu_busy}), 6);
        do_read(14'h0021);
        do_read(14'h0010);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule